// File: doc/BRIEF.md
# MII management access controller

This block sits between a host register interface and the management side of an Ethernet PHY. The host stores a PHY address and a register address in an address register. Each accepted read or write of the data register then runs one management transaction. If the stored PHY address is the one reserved for the on-chip PHY, the access goes to a local register port for one cycle, and the external management pins stay quiet. Any other PHY address produces a clause-22 serial frame on MDC/MDIO. MDC is derived from the system clock by a parameterised divider.

While a transaction runs, a busy flag is raised and further data-register accesses are dropped. On completion a one-cycle done pulse appears. For a read, the returned value is placed in the data register, which is always visible on its own output.

A loopback control bit can also redirect the MAC-side receive nibble path so that it is fed from the transmit path.

Top module: `mii_mgmt_ctrl`

## Requirements
- R1: The address register is selected by hostSel=0. It holds the PHY address in bits 9:5 and the register address in bits 4:0. It reads back on hostRdData[9:0] in the same cycle as the select, and it can be written in any cycle, including while busy.
- R2: A host access with hostSel=1 while not busy starts exactly one transaction. hostWrEn starts a write with data hostWrData[15:0]. hostRdEn alone starts a read. If both are high, the access is a write.
- R3: busy is high from the cycle after the accepting edge until the transaction completes. Whenever busy is low, mdc and mdioOe are low.
- R4: PHY address 5'h1F selects the internal port. intReq is high for exactly one cycle, with intWrite set for a write, and intRegAddr and intWrData giving the register address and data. mdc and mdioOe stay low throughout.
- R5: An external frame is 64 MDC periods, sent in this order: 32 ones, start bits 01, opcode (10 read, 01 write), PHY address and register address MSB first, turnaround 10 (write), then 16 data bits MSB first. mdioOut changes only when mdc falls.
- R6: mdc has a period of 2*MDC_HALF clocks. It is low for the first MDC_HALF clocks of a frame and returns low when the frame ends.
- R7: In a read, mdioOe is low from the first turnaround bit (bit 46) to the end of the frame. mdioIn is sampled at the rising mdc edge of each of bits 48..63, MSB first.
- R8: Completion raises done for one cycle. In that same cycle mgmtData shows the read result (internal or external), or it keeps the written value after a write. hostRdData[15:0] with hostSel=1 shows the same register.
- R9: Data-register accesses while busy are ignored. They do not change mgmtData and they do not start or extend a transaction.
- R10: The loopback bit is hostSel=2, bit 0. When it is 1, macRxData=txData, macRxDv=txEn, macRxEr=txEr and macCrs=txEn|macRxDv. When it is 0, the phyRx* and phyCrs inputs pass straight through.
- R11: After reset, busy, done, mdc and mdioOe are low, the loopback bit is 0 and mgmtData is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low hard reset |
| hostWrEn | input | 1 | Host write strobe |
| hostRdEn | input | 1 | Host read strobe |
| hostSel | input | 2 | 0 address, 1 data, 2 control |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data for the selected register |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mgmtData | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Management data out |
| mdioOe | output | 1 | Management data output enable |
| mdioIn | input | 1 | Management data in |
| intReq | output | 1 | Internal PHY register access strobe |
| intWrite | output | 1 | Internal access is a write |
| intRegAddr | output | 5 | Internal register address |
| intWrData | output | 16 | Internal write data |
| intRdData | input | 16 | Internal read data, taken while intReq is high |
| txData | input | 4 | MAC transmit nibble |
| txEn | input | 1 | MAC transmit enable |
| txEr | input | 1 | MAC transmit error |
| phyRxData | input | 4 | PHY receive nibble |
| phyRxDv | input | 1 | PHY receive data valid |
| phyRxEr | input | 1 | PHY receive error |
| phyCrs | input | 1 | PHY carrier sense |
| macRxData | output | 4 | Receive nibble to MAC |
| macRxDv | output | 1 | Receive data valid to MAC |
| macRxEr | output | 1 | Receive error to MAC |
| macCrs | output | 1 | Carrier sense to MAC |

## Verification
The hardest situation to reach is a data-register write that lands in the middle of an external read frame. If it were wrongly accepted, it would corrupt both the frame and the value returned. The stimulus reaches it by starting a read and then issuing a write with a distinct pattern about a hundred cycles in, together with an address update. A PHY responder drives each data bit for the whole MDC period that the reference model predicts. This makes a sample taken on the wrong edge or at the wrong bit index visible in the latched result.

// File: rtl/mii_mgmt_pkg.sv
package mii_mgmt_pkg;
  localparam int PHY_AW       = 5;
  localparam int REG_AW       = 5;
  localparam int DATA_W       = 16;
  localparam int PREAMBLE_LEN = 32;
  localparam int FRAME_LEN    = PREAMBLE_LEN + 4 + PHY_AW + REG_AW + 2 + DATA_W;
  localparam int TA_POS       = PREAMBLE_LEN + 4 + PHY_AW + REG_AW;
  localparam int DATA_POS     = TA_POS + 2;

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CTRL = 2'd2;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_INT  = 2'd1,
    ST_EXT  = 2'd2
  } ctlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic acceptWr;
    logic frameShift;
    logic rxSample;
    logic intLatch;
    logic extLatch;
  } mgmtStrobe_t;
endpackage

// File: rtl/mii_mgmt_ctl.sv
module mii_mgmt_ctl
  import mii_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter logic [PHY_AW-1:0] INT_PHY_ADDR = 5'h1F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [1:0]        hostSel,
  input  logic [PHY_AW-1:0] phyAddr,
  output mgmtStrobe_t       strobe,
  output logic              busy,
  output logic              done,
  output logic              mdc,
  output logic              mdioOe,
  output logic              intReq,
  output logic              intWrite
);
  localparam int IDX_W    = $clog2(FRAME_LEN);
  localparam int LAST_BIT = FRAME_LEN - 1;

  ctlState_e        state;
  logic             opRead;
  logic [IDX_W-1:0] bitIdx;
  logic             mdcQ;
  logic             doneQ;
  logic             tick;
  logic             accept;
  logic             lastBit;

  assign accept  = (hostWrEn || hostRdEn) && (hostSel == SEL_DATA) && (state == ST_IDLE);
  assign lastBit = (bitIdx == IDX_W'(LAST_BIT));

  // MDC half-period timing: divider present only when a half period spans several clocks
  generate
    if (MDC_HALF <= 1) begin : gNoDiv
      assign tick = (state == ST_EXT);
    end else begin : gDiv
      localparam int DIV_W = $clog2(MDC_HALF);
      logic [DIV_W-1:0] divCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                divCnt <= '0;
        else if (state != ST_EXT)                 divCnt <= '0;
        else if (divCnt == DIV_W'(MDC_HALF - 1))  divCnt <= '0;
        else                                      divCnt <= divCnt + 1'b1;
      end
      assign tick = (state == ST_EXT) && (divCnt == DIV_W'(MDC_HALF - 1));
    end
  endgenerate

  always_comb begin
    strobe            = '0;
    strobe.accept     = accept;
    strobe.acceptWr   = accept && hostWrEn;
    strobe.frameShift = tick && mdcQ && !lastBit;
    strobe.rxSample   = tick && !mdcQ && opRead && (bitIdx >= IDX_W'(DATA_POS));
    strobe.intLatch   = (state == ST_INT) && opRead;
    strobe.extLatch   = tick && mdcQ && lastBit && opRead;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      opRead <= 1'b0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            opRead <= !hostWrEn;
            bitIdx <= '0;
            mdcQ   <= 1'b0;
            state  <= (phyAddr == INT_PHY_ADDR) ? ST_INT : ST_EXT;
          end
        end
        ST_INT: begin
          state <= ST_IDLE;
          doneQ <= 1'b1;
        end
        ST_EXT: begin
          if (tick) begin
            if (!mdcQ) begin
              mdcQ <= 1'b1;
            end else begin
              mdcQ <= 1'b0;
              if (lastBit) begin
                state <= ST_IDLE;
                doneQ <= 1'b1;
              end else begin
                bitIdx <= bitIdx + 1'b1;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy     = (state != ST_IDLE);
  assign done     = doneQ;
  assign mdc      = mdcQ;
  assign mdioOe   = (state == ST_EXT) && (!opRead || (bitIdx < IDX_W'(TA_POS)));
  assign intReq   = (state == ST_INT);
  assign intWrite = (state == ST_INT) && !opRead;
endmodule

// File: rtl/mii_mgmt_dp.sv
module mii_mgmt_dp
  import mii_mgmt_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  mgmtStrobe_t       strobe,
  input  logic              hostWrEn,
  input  logic [1:0]        hostSel,
  input  logic [31:0]       hostWrData,
  output logic [31:0]       hostRdData,
  output logic [PHY_AW-1:0] phyAddr,
  output logic [REG_AW-1:0] regAddr,
  output logic [DATA_W-1:0] dataReg,
  output logic              mdioOut,
  input  logic              mdioIn,
  input  logic [DATA_W-1:0] intRdData,
  input  logic [3:0]        txData,
  input  logic              txEn,
  input  logic              txEr,
  input  logic [3:0]        phyRxData,
  input  logic              phyRxDv,
  input  logic              phyRxEr,
  input  logic              phyCrs,
  output logic [3:0]        macRxData,
  output logic              macRxDv,
  output logic              macRxEr,
  output logic              macCrs
);
  logic [PHY_AW-1:0]    phyQ;
  logic [REG_AW-1:0]    regQ;
  logic [DATA_W-1:0]    dataQ;
  logic [DATA_W-1:0]    rxQ;
  logic [FRAME_LEN-1:0] frameQ;
  logic                 loopQ;
  logic [1:0]           opCode;
  logic [1:0]           taBits;
  logic [DATA_W-1:0]    payload;
  logic                 unusedHi;

  assign unusedHi = ^hostWrData[31:16];

  // address register: no reset, writable in any cycle
  always_ff @(posedge clk) begin
    if (hostWrEn && hostSel == SEL_ADDR) {phyQ, regQ} <= hostWrData[PHY_AW+REG_AW-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                               loopQ <= 1'b0;
    else if (hostWrEn && hostSel == SEL_CTRL) loopQ <= hostWrData[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 dataQ <= '0;
    else if (strobe.acceptWr)  dataQ <= hostWrData[DATA_W-1:0];
    else if (strobe.intLatch)  dataQ <= intRdData;
    else if (strobe.extLatch)  dataQ <= rxQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                rxQ <= '0;
    else if (strobe.accept)   rxQ <= '0;
    else if (strobe.rxSample) rxQ <= {rxQ[DATA_W-2:0], mdioIn};
  end

  assign opCode  = hostWrEn ? 2'b01 : 2'b10;
  assign taBits  = hostWrEn ? 2'b10 : 2'b11;
  assign payload = hostWrEn ? hostWrData[DATA_W-1:0] : '1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                  frameQ <= '0;
    else if (strobe.accept)     frameQ <= {{PREAMBLE_LEN{1'b1}}, 2'b01, opCode, phyQ, regQ, taBits, payload};
    else if (strobe.frameShift) frameQ <= {frameQ[FRAME_LEN-2:0], 1'b0};
  end

  always_comb begin
    hostRdData = '0;
    case (hostSel)
      SEL_ADDR: hostRdData[PHY_AW+REG_AW-1:0] = {phyQ, regQ};
      SEL_DATA: hostRdData[DATA_W-1:0]        = dataQ;
      SEL_CTRL: hostRdData[0]                 = loopQ;
      default:  hostRdData = '0;
    endcase
  end

  always_comb begin
    if (loopQ) begin
      macRxData = txData;
      macRxDv   = txEn;
      macRxEr   = txEr;
      macCrs    = txEn | txEn;
    end else begin
      macRxData = phyRxData;
      macRxDv   = phyRxDv;
      macRxEr   = phyRxEr;
      macCrs    = phyCrs;
    end
  end

  assign phyAddr = phyQ;
  assign regAddr = regQ;
  assign dataReg = dataQ;
  assign mdioOut = frameQ[FRAME_LEN-1];
endmodule

// File: rtl/mii_mgmt_ctrl.sv
module mii_mgmt_ctrl
  import mii_mgmt_pkg::*;
#(
  parameter int MDC_HALF = 4,
  parameter logic [4:0] INT_PHY_ADDR = 5'h1F
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [1:0]  hostSel,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  output logic        busy,
  output logic        done,
  output logic [15:0] mgmtData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn,
  output logic        intReq,
  output logic        intWrite,
  output logic [4:0]  intRegAddr,
  output logic [15:0] intWrData,
  input  logic [15:0] intRdData,
  input  logic [3:0]  txData,
  input  logic        txEn,
  input  logic        txEr,
  input  logic [3:0]  phyRxData,
  input  logic        phyRxDv,
  input  logic        phyRxEr,
  input  logic        phyCrs,
  output logic [3:0]  macRxData,
  output logic        macRxDv,
  output logic        macRxEr,
  output logic        macCrs
);
  mgmtStrobe_t       strobe;
  logic [PHY_AW-1:0] phyAddr;

  mii_mgmt_ctl #(.MDC_HALF(MDC_HALF), .INT_PHY_ADDR(INT_PHY_ADDR)) u_ctl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostSel(hostSel),
    .phyAddr(phyAddr), .strobe(strobe), .busy(busy), .done(done), .mdc(mdc),
    .mdioOe(mdioOe), .intReq(intReq), .intWrite(intWrite)
  );

  mii_mgmt_dp u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .hostWrEn(hostWrEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .phyAddr(phyAddr),
    .regAddr(intRegAddr), .dataReg(mgmtData), .mdioOut(mdioOut), .mdioIn(mdioIn),
    .intRdData(intRdData), .txData(txData), .txEn(txEn), .txEr(txEr),
    .phyRxData(phyRxData), .phyRxDv(phyRxDv), .phyRxEr(phyRxEr), .phyCrs(phyCrs),
    .macRxData(macRxData), .macRxDv(macRxDv), .macRxEr(macRxEr), .macCrs(macCrs)
  );

  assign intWrData = mgmtData;
endmodule

// File: rtl/mii_mgmt_chk.sv
module mii_mgmt_chk (
  input logic clk,
  input logic rstN,
  input logic busy,
  input logic done,
  input logic mdc,
  input logic mdioOut,
  input logic mdioOe,
  input logic intReq
);
  a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  a_r4_int_no_frame: assert property (@(posedge clk) disable iff (!rstN)
    intReq |-> (!mdc && !mdioOe));

  a_r4_int_single: assert property (@(posedge clk) disable iff (!rstN)
    intReq |=> !intReq);

  a_r5_mdio_hold_high: assert property (@(posedge clk) disable iff (!rstN)
    mdc |-> $stable(mdioOut));

  a_r7_release_sticks: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && busy && !$past(mdioOe)) |-> !mdioOe);

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_at_end: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);
endmodule

bind mii_mgmt_ctrl mii_mgmt_chk u_chk (
  .clk(clk), .rstN(rstN), .busy(busy), .done(done), .mdc(mdc),
  .mdioOut(mdioOut), .mdioOe(mdioOe), .intReq(intReq)
);

// File: tb/mii_mgmt_ctrl_bench.sv
`timescale 1ns/1ps
module mii_mgmt_ctrl_bench;
  localparam int HALF   = 4;
  localparam int BITT   = 2 * HALF;
  localparam int NBITS  = 64;
  localparam int FCYC   = NBITS * BITT;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [1:0]  hostSel = 2'd3;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        busy, done, mdc, mdioOut, mdioOe, intReq, intWrite;
  logic        mdioIn = 1'b1;
  logic [15:0] mgmtData, intWrData;
  logic [15:0] intRdData = '0;
  logic [4:0]  intRegAddr;
  logic [3:0]  txData = '0, phyRxData = '0, macRxData;
  logic        txEn = 1'b0, txEr = 1'b0, phyRxDv = 1'b0, phyRxEr = 1'b0, phyCrs = 1'b0;
  logic        macRxDv, macRxEr, macCrs;

  mii_mgmt_ctrl #(.MDC_HALF(HALF)) u_mii_mgmt_ctrl (
    .clk(clk), .rstN(rstN), .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostSel(hostSel),
    .hostWrData(hostWrData), .hostRdData(hostRdData), .busy(busy), .done(done),
    .mgmtData(mgmtData), .mdc(mdc), .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn),
    .intReq(intReq), .intWrite(intWrite), .intRegAddr(intRegAddr), .intWrData(intWrData),
    .intRdData(intRdData), .txData(txData), .txEn(txEn), .txEr(txEr),
    .phyRxData(phyRxData), .phyRxDv(phyRxDv), .phyRxEr(phyRxEr), .phyCrs(phyCrs),
    .macRxData(macRxData), .macRxDv(macRxDv), .macRxEr(macRxEr), .macCrs(macCrs)
  );

  int checks = 0, errors = 0;
  bit finished = 0;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // reference model state
  bit          mExt = 0, mInt = 0, mRead = 0, mDone = 0, mLoop = 0, addrSet = 0;
  int          t = 0;
  logic [15:0] mData = '0, rx = '0;
  logic [4:0]  mPhy = '0, mReg = '0;
  logic [63:0] mFrame = '0;
  logic [15:0] phyVal = '0;

  always @(posedge clk) begin : modelProc
    int b;
    if (!rstN) begin
      mExt = 0; mInt = 0; mDone = 0; mData = '0; mLoop = 0; t = 0;
    end else begin
      mDone = 0;
      if (mInt) begin
        if (mRead) mData = intRdData;
        mInt = 0; mDone = 1;
      end else if (mExt) begin
        b = t / BITT;
        if (mRead && b >= 48 && (t % BITT) == HALF - 1) rx = {rx[14:0], mdioIn};
        if (t == FCYC - 1) begin
          mExt = 0; mDone = 1;
          if (mRead) mData = rx;
        end
        t++;
      end else if (hostSel == 2'd1 && (hostWrEn || hostRdEn)) begin
        mRead = !hostWrEn;
        if (hostWrEn) mData = hostWrData[15:0];
        if (mPhy == 5'h1F) mInt = 1;
        else begin
          mExt = 1; t = 0; rx = '0;
          mFrame = {32'hFFFF_FFFF, 2'b01, (mRead ? 2'b10 : 2'b01), mPhy, mReg,
                    (mRead ? 2'b11 : 2'b10), (mRead ? 16'hFFFF : hostWrData[15:0])};
        end
      end
      if (hostWrEn && hostSel == 2'd0) begin {mPhy, mReg} = hostWrData[9:0]; addrSet = 1; end
      if (hostWrEn && hostSel == 2'd2) mLoop = hostWrData[0];
    end
  end

  // PHY responder: drives each read data bit for its whole MDC period
  always @(posedge clk) begin
    #1;
    if (mExt && mRead && (t / BITT) >= 48) mdioIn = phyVal[NBITS - 1 - t / BITT];
    else mdioIn = 1'b1;
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin : cmpProc
    int b;
    if (rstN && !finished) begin
      b = t / BITT;
      chk("R3 busy", busy, mExt || mInt);
      chk("R6 mdc", mdc, mExt ? ((t / HALF) % 2) : 0);
      if (mExt && mRead) chk("R7 mdioOe", mdioOe, b < 46);
      else chk("R3 mdioOe", mdioOe, mExt);
      if (mExt && (!mRead || b < 46)) chk("R5 mdioOut", mdioOut, mFrame[NBITS - 1 - b]);
      chk("R8 done", done, mDone);
      chk("R8 R9 mgmtData", mgmtData, mData);
      chk("R4 intReq", intReq, mInt);
      if (mInt) begin
        chk("R4 intWrite", intWrite, !mRead);
        chk("R4 intRegAddr", intRegAddr, mReg);
        chk("R4 intWrData", intWrData, mData);
      end
      if (hostSel == 2'd0 && addrSet) chk("R1 address readback", hostRdData[9:0], {mPhy, mReg});
      if (hostSel == 2'd1) chk("R8 data readback", hostRdData[15:0], mData);
      chk("R10 macRxData", macRxData, mLoop ? txData : phyRxData);
      chk("R10 macRxDv", macRxDv, mLoop ? txEn : phyRxDv);
      chk("R10 macRxEr", macRxEr, mLoop ? txEr : phyRxEr);
      chk("R10 macCrs", macCrs, mLoop ? txEn : phyCrs);
    end
  end

  task automatic hostAccess(bit wr, bit rd, logic [1:0] sel, logic [31:0] d);
    @(posedge clk); #1;
    hostWrEn = wr; hostRdEn = rd; hostSel = sel; hostWrData = d;
    @(posedge clk); #1;
    hostWrEn = 0; hostRdEn = 0;
  endtask

  task automatic waitIdle();
    do @(posedge clk); while (busy);
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    chk("R11 busy after reset", busy, 0);
    chk("R11 done after reset", done, 0);
    chk("R11 mdc after reset", mdc, 0);
    chk("R11 mdioOe after reset", mdioOe, 0);
    chk("R11 mgmtData after reset", mgmtData, 0);
    chk("R11 loopback clear", macRxData, phyRxData);

    // R1: address, reserved bits zero
    hostAccess(1, 0, 2'd0, {22'd0, 5'h03, 5'h11});
    // R2 R5: external write
    hostAccess(1, 0, 2'd1, 32'h0000_A5C3);
    waitIdle();

    // R7 R9: external read with an ignored write and an address update mid-frame
    phyVal = 16'h3C96;
    hostAccess(0, 1, 2'd1, 32'h0);
    repeat (100) @(posedge clk);
    hostAccess(1, 0, 2'd1, 32'h0000_1234);
    hostAccess(1, 0, 2'd0, {22'd0, 5'h1F, 5'h07});
    waitIdle();
    @(negedge clk);
    chk("R9 write while busy ignored", mgmtData, 16'h3C96);

    // R4: internal write then internal read
    hostAccess(1, 0, 2'd1, 32'h0000_BEEF);
    waitIdle();
    intRdData = 16'h7E81;
    hostAccess(0, 1, 2'd1, 32'h0);
    waitIdle();
    @(negedge clk);
    chk("R4 internal read latched", mgmtData, 16'h7E81);

    // R10: loopback on, varied tx, then off
    phyRxData = 4'h9; phyRxDv = 1; phyRxEr = 0; phyCrs = 0;
    hostAccess(1, 0, 2'd2, 32'h1);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); #1;
      txData = 4'(i * 3 + 1); txEn = i[0]; txEr = i[1];
    end
    hostAccess(1, 0, 2'd2, 32'h0);
    repeat (2) @(posedge clk);

    // R7: read with boundary bit pattern
    hostAccess(1, 0, 2'd0, {22'd0, 5'h00, 5'h1F});
    phyVal = 16'h8001;
    hostAccess(0, 1, 2'd1, 32'h0);
    waitIdle();
    @(negedge clk);
    chk("R7 read edge bits", mgmtData, 16'h8001);

    // R2: write and read together count as a write
    hostAccess(1, 1, 2'd1, 32'h0000_5AA5);
    waitIdle();
    @(negedge clk);
    chk("R2 write priority", mgmtData, 16'h5AA5);

    repeat (5) @(posedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule